// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic core of an 8-bit accumulator machine. Each request carries three things: the current accumulator, a second operand (a scratchpad register, a memory byte or an immediate, as chosen upstream) and a 4-bit operation code. Fifteen operations are covered:

- binary and packed-decimal addition
- AND, OR, XOR and complement
- compare
- single-bit and nibble shifts in both directions
- add-carry-flag, increment, clear and load-low-nibble

One clock after a valid request, the block returns the new accumulator value and a write enable for it. It also returns four status flags and a per-flag write mask. The mask tells the status register which flags this operation owns.

The flag polarity is unusual: the sign flag is set when the result is non-negative. Each class of operation has its own rule for which flags it computes, which it forces and which it leaves untouched. The surrounding sequencer applies the write enable and the mask. The register file, memory access and instruction timing stay outside this block.

Top module: `acc_alu`

## Requirements
- R1: A request presented with `opValid` high produces its outputs, with `resValid` high, on the next rising clock edge. A cycle without `opValid` gives `resValid` low. While `rstN` is low, every output reads 0.
- R2: Flag bit positions are carry = bit 0, zero = bit 1, sign = bit 2 and overflow = bit 3. Add (code 0) writes the 8-bit sum of `accIn` and `operand` and updates all four flags (mask 4'hF):
  - carry is the carry out of bit 7
  - overflow is the carry into bit 7 XOR the carry out of bit 7
  - zero is set when the result is 0x00
  - sign is the inverse of result bit 7
- R3: Decimal add (code 1) of two valid packed-BCD bytes writes their packed-BCD sum modulo 100. Carry is the decimal carry out of the tens digit. Overflow is the binary overflow of the uncorrected sum. Zero and sign follow the written value, and the mask is 4'hF.
- R4: Compare (code 5) computes `operand` minus `accIn` and sets the flags from it under mask 4'hF. Carry is set when `operand` >= `accIn` unsigned, and overflow is the two's-complement overflow of the subtraction. `accWrite` is 0 and `result` equals `accIn`.
- R5: Add-carry (code 11) writes `accIn` + `carryIn`. Increment (code 12) writes `accIn` + 1. Both update all four flags by the rules of R2.
- R6: AND (code 2), OR (code 3), XOR (code 4) and complement (code 10) write their logic result. They force carry and overflow to 0, take zero and sign from the result, and use mask 4'hF.
- R7: Shift left by 1 (code 8) and by 4 (code 9) fill the vacated bits with 0. Carry and overflow are forced to 0, zero and sign come from the result, and the mask is 4'hF.
- R8: Shift right by 1 (code 6) and by 4 (code 7) fill the vacated bits with 0. Sign is forced to 1, carry and overflow are forced to 0, zero comes from the result, and the mask is 4'hF.
- R9: Clear (code 13) writes 0x00. Load-nibble (code 14) writes 0 in the high nibble and `operand[3:0]` in the low nibble. Neither touches any flag (mask 4'h0).
- R10: Code 15 is reserved. It gives `accWrite` = 0, mask 4'h0 and `result` equal to `accIn`.
- R11: Any flag bit whose mask bit is 0 reads 0 on `flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Request strobe |
| opSel | input | 4 | Operation code |
| accIn | input | 8 | Current accumulator |
| operand | input | 8 | Second operand |
| carryIn | input | 1 | Current carry flag, used by add-carry |
| resValid | output | 1 | Outputs hold a finished request |
| result | output | 8 | Next accumulator value |
| accWrite | output | 1 | Accumulator should be written |
| flags | output | 4 | Flag values {overflow, sign, zero, carry} |
| flagMask | output | 4 | Flags this operation writes, same bit order |

## Verification
Decimal add is the one path where two corrections and a carry out of the byte all happen in a single operation. The units-digit fix ripples into the tens digit, which then needs its own fix and raises the decimal carry. The bench forces this with 0x99 + 0x99, which must give 0x98 with carry set, and with random valid-BCD pairs. Each result is judged against a bench model that converts the operands to integers and converts the sum back. Carry and overflow rising together in binary add is also covered, directed by 0x80 + 0x80 and judged against integer arithmetic.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_DADD  = 4'd1,
    OP_AND   = 4'd2,
    OP_OR    = 4'd3,
    OP_XOR   = 4'd4,
    OP_CMP   = 4'd5,
    OP_SHR1  = 4'd6,
    OP_SHR4  = 4'd7,
    OP_SHL1  = 4'd8,
    OP_SHL4  = 4'd9,
    OP_COM   = 4'd10,
    OP_LNK   = 4'd11,
    OP_INC   = 4'd12,
    OP_CLR   = 4'd13,
    OP_LDNIB = 4'd14,
    OP_RSVD  = 4'd15
  } aluOp_e;

  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_S = 2;
  localparam int FLAG_O = 3;

  typedef enum logic [2:0] {
    RS_SUM, RS_BCD, RS_AND, RS_OR, RS_XOR, RS_SHIFT, RS_NIB, RS_ZERO
  } resSel_e;

  typedef enum logic [1:0] {
    CI_ZERO, CI_ONE, CI_FLAG
  } carrySel_e;

  typedef struct packed {
    resSel_e   resSel;
    logic      swapSub;
    logic      addOperand;
    carrySel_e carrySel;
    logic      shiftLeft;
    logic      shiftNib;
    logic      invertB;
    logic      accWrite;
    logic [3:0] flagMask;
    logic      arithFlags;
    logic      forceSign;
  } aluCtrl_t;

endpackage

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import acc_alu_pkg::*;
(
  input  logic [3:0] opCode,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl = '{resSel: RS_SUM, swapSub: 1'b0, addOperand: 1'b0, carrySel: CI_ZERO,
             shiftLeft: 1'b0, shiftNib: 1'b0, invertB: 1'b0, accWrite: 1'b1,
             flagMask: 4'hF, arithFlags: 1'b0, forceSign: 1'b0};
    case (aluOp_e'(opCode))
      OP_ADD: begin
        ctrl.addOperand = 1'b1;
        ctrl.arithFlags = 1'b1;
      end
      OP_DADD: begin
        ctrl.resSel     = RS_BCD;
        ctrl.addOperand = 1'b1;
        ctrl.arithFlags = 1'b1;
      end
      OP_AND: ctrl.resSel = RS_AND;
      OP_OR:  ctrl.resSel = RS_OR;
      OP_XOR: ctrl.resSel = RS_XOR;
      OP_CMP: begin
        ctrl.swapSub    = 1'b1;
        ctrl.carrySel   = CI_ONE;
        ctrl.arithFlags = 1'b1;
        ctrl.accWrite   = 1'b0;
      end
      OP_SHR1: begin
        ctrl.resSel    = RS_SHIFT;
        ctrl.forceSign = 1'b1;
      end
      OP_SHR4: begin
        ctrl.resSel    = RS_SHIFT;
        ctrl.shiftNib  = 1'b1;
        ctrl.forceSign = 1'b1;
      end
      OP_SHL1: begin
        ctrl.resSel    = RS_SHIFT;
        ctrl.shiftLeft = 1'b1;
      end
      OP_SHL4: begin
        ctrl.resSel    = RS_SHIFT;
        ctrl.shiftLeft = 1'b1;
        ctrl.shiftNib  = 1'b1;
      end
      OP_COM: begin
        ctrl.resSel  = RS_XOR;
        ctrl.invertB = 1'b1;
      end
      OP_LNK: begin
        ctrl.carrySel   = CI_FLAG;
        ctrl.arithFlags = 1'b1;
      end
      OP_INC: begin
        ctrl.carrySel   = CI_ONE;
        ctrl.arithFlags = 1'b1;
      end
      OP_CLR: begin
        ctrl.resSel   = RS_ZERO;
        ctrl.flagMask = 4'h0;
      end
      OP_LDNIB: begin
        ctrl.resSel   = RS_NIB;
        ctrl.flagMask = 4'h0;
      end
      default: begin
        ctrl.accWrite = 1'b0;
        ctrl.flagMask = 4'h0;
      end
    endcase
  end

endmodule

// File: rtl/acc_alu_dp.sv
module acc_alu_dp
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  input  aluCtrl_t          ctrl,
  output logic              resValid,
  output logic [DATA_W-1:0] result,
  output logic              accWrite,
  output logic [3:0]        flags,
  output logic [3:0]        flagMask
);

  localparam int NIBS = DATA_W / 4;

  // shared binary adder
  logic [DATA_W-1:0] addX, addY;
  logic              addCin;
  logic [DATA_W:0]   sumFull;
  logic [DATA_W-1:0] lowSum;
  logic              carryIntoMsb, binOvf;

  always_comb begin
    if (ctrl.swapSub) begin
      addX = operand;
      addY = ~accIn;
    end else begin
      addX = accIn;
      addY = ctrl.addOperand ? operand : '0;
    end
    case (ctrl.carrySel)
      CI_ONE:  addCin = 1'b1;
      CI_FLAG: addCin = carryIn;
      default: addCin = 1'b0;
    endcase
  end

  assign sumFull = {1'b0, addX} + {1'b0, addY} + {{DATA_W{1'b0}}, addCin};
  assign lowSum  = {1'b0, addX[DATA_W-2:0]} + {1'b0, addY[DATA_W-2:0]}
                 + {{(DATA_W-1){1'b0}}, addCin};
  assign carryIntoMsb = lowSum[DATA_W-1];
  assign binOvf       = carryIntoMsb ^ sumFull[DATA_W];

  // digit-serial decimal adder, one corrected nibble per stage
  logic [NIBS:0]     decCarry;
  logic [DATA_W-1:0] bcdSum;
  assign decCarry[0] = 1'b0;

  for (genvar g = 0; g < NIBS; g++) begin : gDigit
    logic [4:0] rawDigit;
    logic       needFix;
    assign rawDigit = {1'b0, accIn[4*g +: 4]} + {1'b0, operand[4*g +: 4]}
                    + {4'b0, decCarry[g]};
    assign needFix  = rawDigit > 5'd9;
    assign bcdSum[4*g +: 4] = needFix ? (rawDigit[3:0] + 4'd6) : rawDigit[3:0];
    assign decCarry[g+1]    = needFix;
  end

  // shifter
  logic [DATA_W-1:0] shiftVal;
  always_comb begin
    case ({ctrl.shiftLeft, ctrl.shiftNib})
      2'b00:   shiftVal = accIn >> 1;
      2'b01:   shiftVal = accIn >> 4;
      2'b10:   shiftVal = accIn << 1;
      default: shiftVal = accIn << 4;
    endcase
  end

  // result select
  logic [DATA_W-1:0] logicB, aluVal;
  assign logicB = ctrl.invertB ? {DATA_W{1'b1}} : operand;

  always_comb begin
    case (ctrl.resSel)
      RS_SUM:   aluVal = sumFull[DATA_W-1:0];
      RS_BCD:   aluVal = bcdSum;
      RS_AND:   aluVal = accIn & logicB;
      RS_OR:    aluVal = accIn | logicB;
      RS_XOR:   aluVal = accIn ^ logicB;
      RS_SHIFT: aluVal = shiftVal;
      RS_NIB:   aluVal = {{(DATA_W-4){1'b0}}, operand[3:0]};
      default:  aluVal = '0;
    endcase
  end

  // flag formation
  logic [3:0] flagsNext;
  always_comb begin
    flagsNext         = '0;
    flagsNext[FLAG_C] = ctrl.arithFlags &
                        ((ctrl.resSel == RS_BCD) ? decCarry[NIBS] : sumFull[DATA_W]);
    flagsNext[FLAG_O] = ctrl.arithFlags & binOvf;
    flagsNext[FLAG_Z] = (aluVal == '0);
    flagsNext[FLAG_S] = ctrl.forceSign | ~aluVal[DATA_W-1];
    flagsNext         = flagsNext & ctrl.flagMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      result   <= '0;
      accWrite <= 1'b0;
      flags    <= '0;
      flagMask <= '0;
    end else begin
      resValid <= inValid;
      if (inValid) begin
        result   <= ctrl.accWrite ? aluVal : accIn;
        accWrite <= ctrl.accWrite;
        flags    <= flagsNext;
        flagMask <= ctrl.flagMask;
      end
    end
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opSel,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  output logic              resValid,
  output logic [DATA_W-1:0] result,
  output logic              accWrite,
  output logic [3:0]        flags,
  output logic [3:0]        flagMask
);

  aluCtrl_t ctrl;

  acc_alu_ctrl uCtrl (
    .opCode (opSel),
    .ctrl   (ctrl)
  );

  acc_alu_dp #(.DATA_W(DATA_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (opValid),
    .accIn    (accIn),
    .operand  (operand),
    .carryIn  (carryIn),
    .ctrl     (ctrl),
    .resValid (resValid),
    .result   (result),
    .accWrite (accWrite),
    .flags    (flags),
    .flagMask (flagMask)
  );

endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [3:0]        opSel,
  input logic [DATA_W-1:0] accIn,
  input logic              resValid,
  input logic [DATA_W-1:0] result,
  input logic              accWrite,
  input logic [3:0]        flags,
  input logic [3:0]        flagMask
);

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> resValid == $past(opValid));

  // R4
  compare_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && resValid && $past(opSel) == OP_CMP)
      |-> (!accWrite && result == $past(accIn) && flagMask == 4'hF));

  // R6
  logic_clears_co_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && resValid && ($past(opSel) == OP_AND || $past(opSel) == OP_OR ||
                                 $past(opSel) == OP_XOR || $past(opSel) == OP_COM))
      |-> (!flags[FLAG_C] && !flags[FLAG_O] && flagMask == 4'hF));

  // R8
  shift_right_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && resValid && ($past(opSel) == OP_SHR1 || $past(opSel) == OP_SHR4))
      |-> (flags[FLAG_S] && !flags[FLAG_C] && !flags[FLAG_O] && !result[DATA_W-1]));

  // R2
  zero_matches_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && accWrite && flagMask[FLAG_Z]) |-> flags[FLAG_Z] == (result == '0));

  // R2
  sign_matches_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && accWrite && flagMask[FLAG_S]) |-> flags[FLAG_S] == ~result[DATA_W-1]);

  // R11
  masked_flags_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (flags & ~flagMask) == 4'h0);

  // R10
  reserved_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && resValid && $past(opSel) == OP_RSVD)
      |-> (!accWrite && flagMask == 4'h0));

endmodule

bind acc_alu acc_alu_checker #(.DATA_W(DATA_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .opValid  (opValid),
  .opSel    (opSel),
  .accIn    (accIn),
  .resValid (resValid),
  .result   (result),
  .accWrite (accWrite),
  .flags    (flags),
  .flagMask (flagMask)
);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;

  logic       clk = 1'b0;
  logic       rstN;
  logic       opValid;
  logic [3:0] opSel;
  logic [7:0] accIn, operand;
  logic       carryIn;
  logic       resValid, accWrite;
  logic [7:0] result;
  logic [3:0] flags, flagMask;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  acc_alu dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel),
    .accIn(accIn), .operand(operand), .carryIn(carryIn),
    .resValid(resValid), .result(result), .accWrite(accWrite),
    .flags(flags), .flagMask(flagMask)
  );

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd5: return "R4";
      4'd11, 4'd12: return "R5";
      4'd2, 4'd3, 4'd4, 4'd10: return "R6";
      4'd8, 4'd9: return "R7";
      4'd6, 4'd7: return "R8";
      4'd13, 4'd14: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic int bcdVal(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic addOvf(input int x, input int y);
    int s;
    s = x + y;
    return (s > 127) || (s < -128);
  endfunction

  function automatic int sx(input logic [7:0] v);
    return v[7] ? int'(v) - 256 : int'(v);
  endfunction

  function automatic void model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                                input logic ci, output logic [7:0] r, output logic w,
                                output logic [3:0] f, output logic [3:0] m);
    int s;
    logic [7:0] v;
    logic c, o;
    c = 0; o = 0; w = 1; m = 4'hF; v = 8'h00;
    case (op)
      4'd0: begin s = int'(a) + int'(b); v = s[7:0]; c = s > 255; o = addOvf(sx(a), sx(b)); end
      4'd1: begin
        s = bcdVal(a) + bcdVal(b);
        c = s >= 100;
        s = s % 100;
        v = {4'(s / 10), 4'(s % 10)};
        o = addOvf(sx(a), sx(b));
      end
      4'd2: v = a & b;
      4'd3: v = a | b;
      4'd4: v = a ^ b;
      4'd5: begin
        s = int'(b) - int'(a); v = s[7:0]; c = b >= a;
        o = addOvf(sx(b), -sx(a)); w = 0;
      end
      4'd6: v = a >> 1;
      4'd7: v = a >> 4;
      4'd8: v = a << 1;
      4'd9: v = a << 4;
      4'd10: v = ~a;
      4'd11: begin s = int'(a) + int'(ci); v = s[7:0]; c = s > 255; o = addOvf(sx(a), int'(ci)); end
      4'd12: begin s = int'(a) + 1; v = s[7:0]; c = s > 255; o = addOvf(sx(a), 1); end
      4'd13: begin v = 8'h00; m = 4'h0; end
      4'd14: begin v = {4'h0, b[3:0]}; m = 4'h0; end
      default: begin w = 0; m = 4'h0; end
    endcase
    f = {o, ~v[7], v == 8'h00, c} & m;
    r = w ? v : a;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic runOp(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic ci);
    logic [7:0] er;
    logic ew;
    logic [3:0] ef, em;
    string rq;
    opValid = 1'b1; opSel = op; accIn = a; operand = b; carryIn = ci;
    @(posedge clk);
    @(negedge clk);
    opValid = 1'b0;
    model(op, a, b, ci, er, ew, ef, em);
    rq = reqOf(op);
    chk("R1", "resValid", int'(resValid), 1);
    chk(rq, "result", int'(result), int'(er));
    chk(rq, "accWrite", int'(accWrite), int'(ew));
    chk(rq, "flags", int'(flags), int'(ef));
    chk(rq, "mask", int'(flagMask), int'(em));
    // R11: flags outside the mask stay 0
    chk("R11", "unmasked flags", int'(flags & ~flagMask), 0);
  endtask

  initial begin
    #(4 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int seedDummy;
    logic [3:0] rop;
    logic [7:0] ra, rb;
    seedDummy = $urandom(32'd7319);
    rstN = 1'b0; opValid = 1'b0; opSel = 4'd0; accIn = 8'h00; operand = 8'h00; carryIn = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "reset resValid", int'(resValid), 0);
    chk("R1", "reset result", int'(result), 0);
    chk("R1", "reset flags", int'(flags), 0);
    chk("R1", "reset mask", int'(flagMask), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "idle resValid", int'(resValid), 0);

    // directed corners
    runOp(4'd0, 8'h7F, 8'h01, 1'b0);   // R2 overflow, sign clear
    runOp(4'd0, 8'hFF, 8'h01, 1'b0);   // R2 carry and zero
    runOp(4'd0, 8'h80, 8'h80, 1'b0);   // R2 carry with overflow
    runOp(4'd1, 8'h99, 8'h99, 1'b0);   // R3 double correction -> 98, carry
    runOp(4'd1, 8'h45, 8'h55, 1'b0);   // R3 -> 00 carry zero
    runOp(4'd1, 8'h19, 8'h01, 1'b0);   // R3 units fix only
    runOp(4'd5, 8'h42, 8'h42, 1'b0);   // R4 equal
    runOp(4'd5, 8'h10, 8'h05, 1'b0);   // R4 borrow
    runOp(4'd5, 8'h01, 8'h80, 1'b0);   // R4 overflow
    runOp(4'd11, 8'hFF, 8'h00, 1'b1);  // R5 add carry wraps
    runOp(4'd11, 8'h33, 8'h00, 1'b0);  // R5 add carry clear
    runOp(4'd12, 8'h7F, 8'h00, 1'b0);  // R5 increment overflow
    runOp(4'd10, 8'hFF, 8'h00, 1'b0);  // R6 complement to zero
    runOp(4'd2, 8'hF0, 8'h0F, 1'b0);   // R6 AND zero
    runOp(4'd9, 8'h81, 8'h00, 1'b0);   // R7
    runOp(4'd8, 8'h80, 8'h00, 1'b0);   // R7 shift out to zero
    runOp(4'd6, 8'h01, 8'h00, 1'b0);   // R8 to zero
    runOp(4'd7, 8'hF5, 8'h00, 1'b0);   // R8
    runOp(4'd13, 8'hA5, 8'h00, 1'b1);  // R9 clear
    runOp(4'd14, 8'hA5, 8'hC7, 1'b0);  // R9 load nibble
    runOp(4'd15, 8'h3C, 8'hFF, 1'b1);  // R10 reserved

    // constrained random
    for (int i = 0; i < 800; i++) begin
      rop = 4'($urandom_range(0, 15));
      ra = 8'($urandom);
      rb = 8'($urandom);
      if (rop == 4'd1) begin
        ra = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
        rb = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
      end
      runOp(rop, ra, rb, 1'($urandom));
    end

    @(negedge clk);
    chk("R1", "idle after run", int'(resValid), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    finished = 1;
    $finish;
  end

endmodule